// File: doc/BRIEF.md
# DTMF Transceiver Host Register Interface

This block is the processor-facing register file of a dual-tone signalling transceiver. A host reaches it over an asynchronous strobe bus: active-low chip select, active-low read and write strobes, one register-select line and a 4-bit data path. The path is split at the pad into an input, an output and an output enable. Behind the bus are a write-only transmit code register, a read-only receive code register, two control registers that share one address, and a read-only status register.

The block exchanges signals with the transmit and receive engines on the same clock. It takes in a transmitter-ready pulse, a receive-valid pulse with its 4-bit code, a delayed-steering level and a hard-limited call-progress squarewave. It hands back the transmit code with a load pulse and the decoded control fields. It also drives a single open-drain alert pin, modelled as a pull-low enable. That pin shows pending work, the call-progress squarewave or the steering level, depending on the mode.

All bus strobes are synchronized to the system clock, and each access acts once, at its trailing edge.

Top module: `dtmf_host_regs`

## Requirements
- R1: A write with register select low stores the 4-bit bus value as the transmit code and gives one `tx_load` pulse.
- R2: A read with register select low returns the code that came with the most recent `rx_valid` pulse.
- R3: A read with register select high returns the status register.
- R4: `bus_oe` is low unless chip select and the read strobe are both asserted.
- R5: A control write that is not redirected updates the first control register: bit 0 tone enable, bit 1 call-progress mode (1) or tone mode (0), bit 2 alert enable, bit 3 redirect.
- R6: After a first-register write with bit 3 set, the next control write goes to the second register only. The write after that goes to the first register again.
- R7: The second control register holds: bit 0 burst disable (0 means burst mode is on, seen as `burst_en`), bit 1 test mode, bit 2 single tone, bit 3 column select.
- R8: The status layout is: bit 3 the steering level, bit 2 receive-full (set by `rx_valid`), bit 1 transmit-empty (set by `tx_ready`), bit 0 the OR of bits 1 and 2.
- R9: The trailing edge of a status read clears status bits 0 to 2 once. An event that arrives in the same cycle as the clear is kept.
- R10: While burst mode is off, transmit-empty stays clear and `tx_ready` has no effect on it.
- R11: With alerts enabled in tone mode, `irq_pull_low` is high while status bit 0 is set.
- R12: With alerts enabled in call-progress mode, `irq_pull_low` is the inverse of `cp_square`.
- R13: With test mode on in tone mode, `irq_pull_low` is the inverse of `steer_flag`.
- R14: After reset both control registers are zero, status bits 0 to 2 are clear, the bus is not driven and the pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rsel | input | 1 | Register select |
| bus_in | input | 4 | Data from host |
| bus_out | output | 4 | Data to host |
| bus_oe | output | 1 | Drive enable for bus_out |
| tx_ready | input | 1 | Transmitter finished burst and pause |
| rx_valid | input | 1 | New received code pulse |
| rx_code | input | 4 | Received code |
| steer_flag | input | 1 | Delayed steering level |
| cp_square | input | 1 | Limited call-progress squarewave |
| tx_code | output | 4 | Stored transmit code |
| tx_load | output | 1 | One-cycle pulse on transmit write |
| tone_en | output | 1 | Tone output enable |
| cp_mode | output | 1 | Call-progress mode selected |
| burst_en | output | 1 | Burst mode active |
| test_mode | output | 1 | Test mode active |
| single_tone | output | 1 | Single tone selected |
| col_sel | output | 1 | Column group selected for single tone |
| irq_pull_low | output | 1 | Pull-low enable of the alert pin |

## Verification
The control path is driven with a sequence of redirect and plain writes. This shows whether the one-shot redirect lands in the second register, returns to the first, and leaves the other register alone. The status path is driven with receive events, transmit events with burst mode on and off, and back-to-back status reads. These patterns separate a clear-on-read from a sticky flag and a gated flag from an ungated one. The alert pin is tried in each of its three modes, with both levels of its source, so that a wrong mode priority or an inverted source shows up.

// File: rtl/dtmf_host_pkg.sv
package dtmf_host_pkg;
  localparam int DW = 4;

  typedef struct packed {
    logic redirect;
    logic irq_en;
    logic cp_mode;
    logic tone_en;
  } ctl_a_t;

  typedef struct packed {
    logic col_sel;
    logic single_tone;
    logic test_mode;
    logic burst_off;
  } ctl_b_t;
endpackage

// File: rtl/dtmf_bus_sync.sv
module dtmf_bus_sync #(
  parameter int STAGES = 2,
  parameter int DW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          rsel,
  input  logic [DW-1:0] bus_in,
  output logic          rd_active,
  output logic          rd_sel,
  output logic          rd_done,
  output logic          wr_done,
  output logic          ev_sel,
  output logic [DW-1:0] ev_data
);
  localparam int W = DW + 4;
  localparam logic [W-1:0] IDLE = {3'b111, {(DW+1){1'b0}}};

  logic [STAGES-1:0][W-1:0] sh_q;
  logic [W-1:0] raw, s;
  logic rd_act, wr_act, rd_act_q, wr_act_q;
  logic hold_sel_q, hold_sel_d;
  logic [DW-1:0] hold_dat_q, hold_dat_d;

  assign raw = {cs_n, rd_n, wr_n, rsel, bus_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) sh_q[i] <= IDLE;
    end else begin
      sh_q[0] <= raw;
      for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
    end
  end

  assign s      = sh_q[STAGES-1];
  assign rd_act = ~s[W-1] & ~s[W-2];
  assign wr_act = ~s[W-1] & ~s[W-3];

  always_comb begin
    hold_sel_d = hold_sel_q;
    hold_dat_d = hold_dat_q;
    if (rd_act || wr_act) begin
      hold_sel_d = s[DW];
      hold_dat_d = s[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q   <= 1'b0;
      wr_act_q   <= 1'b0;
      hold_sel_q <= 1'b0;
      hold_dat_q <= '0;
    end else begin
      rd_act_q   <= rd_act;
      wr_act_q   <= wr_act;
      hold_sel_q <= hold_sel_d;
      hold_dat_q <= hold_dat_d;
    end
  end

  assign rd_active = rd_act;
  assign rd_sel    = s[DW];
  assign rd_done   = rd_act_q & ~rd_act;
  assign wr_done   = wr_act_q & ~wr_act;
  assign ev_sel    = hold_sel_q;
  assign ev_data   = hold_dat_q;

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done); // R9
endmodule

// File: rtl/dtmf_ctrl_regs.sv
module dtmf_ctrl_regs
  import dtmf_host_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  output ctl_a_t        ctl_a,
  output ctl_b_t        ctl_b
);
  ctl_a_t a_q, a_d;
  ctl_b_t b_q, b_d;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (wr_ctrl) begin
      if (a_q.redirect) begin
        b_d          = ctl_b_t'(wdata);
        a_d.redirect = 1'b0;
      end else begin
        a_d = ctl_a_t'(wdata);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign ctl_a = a_q;
  assign ctl_b = b_q;

  AST_REDIRECT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && a_q.redirect) |=> !a_q.redirect); // R6
  AST_REDIRECT_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && a_q.redirect) |=> $stable(a_q[2:0])); // R6
endmodule

// File: rtl/dtmf_status_flags.sv
module dtmf_status_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_stat,
  input  logic       tx_ready,
  input  logic       rx_valid,
  input  logic       burst_en,
  input  logic       steer_flag,
  output logic [3:0] status
);
  logic txe_q, txe_d, rxf_q, rxf_d;

  always_comb begin
    txe_d = txe_q;
    if (!burst_en)    txe_d = 1'b0;
    else if (tx_ready) txe_d = 1'b1;
    else if (rd_stat)  txe_d = 1'b0;

    rxf_d = rxf_q;
    if (rx_valid)     rxf_d = 1'b1;
    else if (rd_stat) rxf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe_q <= 1'b0;
      rxf_q <= 1'b0;
    end else begin
      txe_q <= txe_d;
      rxf_q <= rxf_d;
    end
  end

  assign status = {steer_flag, rxf_q, txe_q, rxf_q | txe_q};

  AST_TXE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_en |=> !txe_q); // R10
  AST_RXF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rxf_q); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !rx_valid) |=> !rxf_q); // R9
endmodule

// File: rtl/dtmf_host_regs.sv
module dtmf_host_regs
  import dtmf_host_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          rsel,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_code,
  input  logic          steer_flag,
  input  logic          cp_square,
  output logic [DW-1:0] tx_code,
  output logic          tx_load,
  output logic          tone_en,
  output logic          cp_mode,
  output logic          burst_en,
  output logic          test_mode,
  output logic          single_tone,
  output logic          col_sel,
  output logic          irq_pull_low
);
  logic rd_active, rd_sel, rd_done, wr_done, ev_sel;
  logic [DW-1:0] ev_data;
  logic [3:0] status;
  ctl_a_t ctl_a;
  ctl_b_t ctl_b;
  logic [DW-1:0] tx_q, tx_d, rx_q, rx_d;
  logic wr_tx, wr_ctrl, rd_stat;

  dtmf_bus_sync #(.STAGES(SYNC_STAGES), .DW(DW)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .rsel(rsel), .bus_in(bus_in), .rd_active(rd_active), .rd_sel(rd_sel),
    .rd_done(rd_done), .wr_done(wr_done), .ev_sel(ev_sel), .ev_data(ev_data)
  );

  assign wr_tx   = wr_done & ~ev_sel;
  assign wr_ctrl = wr_done &  ev_sel;
  assign rd_stat = rd_done &  ev_sel;

  dtmf_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(ev_data),
    .ctl_a(ctl_a), .ctl_b(ctl_b)
  );

  dtmf_status_flags u_stat (
    .clk(clk), .rst_n(rst_n), .rd_stat(rd_stat), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .burst_en(burst_en), .steer_flag(steer_flag),
    .status(status)
  );

  always_comb begin
    tx_d = wr_tx    ? ev_data : tx_q;
    rx_d = rx_valid ? rx_code : rx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign bus_oe      = rd_active;
  assign bus_out     = rd_sel ? status : rx_q;
  assign tx_code     = tx_q;
  assign tx_load     = wr_tx;
  assign tone_en     = ctl_a.tone_en;
  assign cp_mode     = ctl_a.cp_mode;
  assign burst_en    = ~ctl_b.burst_off;
  assign test_mode   = ctl_b.test_mode;
  assign single_tone = ctl_b.single_tone;
  assign col_sel     = ctl_b.col_sel;

  always_comb begin
    irq_pull_low = 1'b0;
    if (ctl_b.test_mode && !ctl_a.cp_mode) irq_pull_low = ~steer_flag;
    else if (ctl_a.irq_en && ctl_a.cp_mode) irq_pull_low = ~cp_square;
    else if (ctl_a.irq_en)                  irq_pull_low = status[0];
  end

  AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_a.irq_en && !ctl_b.test_mode) |-> !irq_pull_low); // R11
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !bus_oe); // R4
endmodule

// File: tb/dtmf_host_regs_bench.sv
module dtmf_host_regs_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic cs_n, rd_n, wr_n, rsel;
  logic [3:0] bus_in, bus_out, rx_code, tx_code;
  logic bus_oe, tx_ready, rx_valid, steer_flag, cp_square, tx_load;
  logic tone_en, cp_mode, burst_en, test_mode, single_tone, col_sel, irq_pull_low;
  int errors = 0;
  int checks = 0;
  int loads  = 0;
  bit done   = 1'b0;
  logic [3:0] rdv;
  logic rdoe;

  always #5 clk = ~clk;

  dtmf_host_regs u_dtmf_host_regs (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .rsel(rsel), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_code(rx_code),
    .steer_flag(steer_flag), .cp_square(cp_square), .tx_code(tx_code),
    .tx_load(tx_load), .tone_en(tone_en), .cp_mode(cp_mode),
    .burst_en(burst_en), .test_mode(test_mode), .single_tone(single_tone),
    .col_sel(col_sel), .irq_pull_low(irq_pull_low)
  );

  always @(posedge clk) if (tx_load) loads <= loads + 1;

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic sel, logic [3:0] d);
    @(negedge clk); rsel = sel; bus_in = d; cs_n = 1'b0; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_read(logic sel);
    @(negedge clk); rsel = sel; cs_n = 1'b0; rd_n = 1'b0;
    repeat (5) @(negedge clk);
    rdv = bus_out; rdoe = bus_oe;
    cs_n = 1'b1; rd_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_rx(logic [3:0] c);
    @(negedge clk); rx_code = c; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic pulse_tx();
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R14 bus_oe", {3'b0, bus_oe}, 4'h0);
    chk("R14 pin", {3'b0, irq_pull_low}, 4'h0);
    chk("R14 ctl", {tone_en, cp_mode, test_mode, single_tone}, 4'h0);
    chk("R14 burst_en", {3'b0, burst_en}, 4'h1);
    bus_read(1'b1);
    chk("R14 status", rdv, 4'h0);
  endtask

  task automatic t_hiz();
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R4 cs only", {3'b0, bus_oe}, 4'h0);
    cs_n = 1'b1; rd_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R4 rd only", {3'b0, bus_oe}, 4'h0);
    rd_n = 1'b1;
    repeat (5) @(negedge clk);
    bus_read(1'b0);
    chk("R4 both", {3'b0, rdoe}, 4'h1);
  endtask

  task automatic t_tx();
    int l0 = loads;
    bus_write(1'b0, 4'h7);
    chk("R1 code", tx_code, 4'h7);
    chk("R1 load pulses", 4'(loads - l0), 4'h1);
  endtask

  task automatic t_ctrl();
    bus_write(1'b1, 4'b0101);
    chk("R5 cra", {2'b0, cp_mode, tone_en}, 4'b0001);
    bus_write(1'b1, 4'b1101);
    bus_write(1'b1, 4'b0110);
    chk("R7 crb", {col_sel, single_tone, test_mode, ~burst_en}, 4'b0110);
    chk("R6 cra kept", {3'b0, tone_en}, 4'h1);
    bus_write(1'b1, 4'b0010);
    chk("R6 back to A", {2'b0, cp_mode, tone_en}, 4'b0010);
    chk("R6 crb kept", {col_sel, single_tone, test_mode, ~burst_en}, 4'b0110);
    bus_write(1'b1, 4'b1000);
    bus_write(1'b1, 4'b0000);
    bus_write(1'b1, 4'b0100);
  endtask

  task automatic t_rx();
    pulse_rx(4'h9);
    repeat (2) @(negedge clk);
    chk("R11 pin pending", {3'b0, irq_pull_low}, 4'h1);
    bus_read(1'b0);
    chk("R2 rx code", rdv, 4'h9);
    bus_read(1'b1);
    chk("R3 R8 status rx", rdv, 4'b0101);
    chk("R11 pin cleared", {3'b0, irq_pull_low}, 4'h0);
    bus_read(1'b1);
    chk("R9 cleared", rdv, 4'h0);
    pulse_rx(4'h3);
    bus_read(1'b1);
    chk("R9 new event kept", rdv, 4'b0101);
  endtask

  task automatic t_burst();
    pulse_tx();
    bus_read(1'b1);
    chk("R8 tx empty", rdv, 4'b0011);
    bus_write(1'b1, 4'b1000);
    bus_write(1'b1, 4'b0001);
    chk("R7 burst off", {3'b0, burst_en}, 4'h0);
    pulse_tx();
    bus_read(1'b1);
    chk("R10 gated", rdv, 4'h0);
  endtask

  task automatic t_cp();
    bus_write(1'b1, 4'b0110);
    cp_square = 1'b1; repeat (2) @(negedge clk);
    chk("R12 sq high", {3'b0, irq_pull_low}, 4'h0);
    cp_square = 1'b0; repeat (2) @(negedge clk);
    chk("R12 sq low", {3'b0, irq_pull_low}, 4'h1);
  endtask

  task automatic t_test();
    bus_write(1'b1, 4'b1000);
    bus_write(1'b1, 4'b0010);
    steer_flag = 1'b1; repeat (2) @(negedge clk);
    chk("R13 steer high", {3'b0, irq_pull_low}, 4'h0);
    bus_read(1'b1);
    chk("R8 steer bit", rdv, 4'b1000);
    steer_flag = 1'b0; repeat (2) @(negedge clk);
    chk("R13 steer low", {3'b0, irq_pull_low}, 4'h1);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; rsel = 1'b0;
    bus_in = '0; rx_code = '0; tx_ready = 1'b0; rx_valid = 1'b0;
    steer_flag = 1'b0; cp_square = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_hiz();
    t_tx();
    t_ctrl();
    t_rx();
    t_burst();
    t_cp();
    t_test();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule